// File: doc/BRIEF.md
# Predicated SIMD Lane Array

A group of identical lanes executes one shared stream of already decoded instructions in lockstep. Every lane owns a small register file and a condition code made of a sign flag and a zero flag. A compare instruction sets each lane's code from that lane's own operands. Any instruction, including a compare, carries a predicate field. A lane whose predicate test fails still spends the instruction's cycle with the others, but it changes no register, no flag and no memory.

Loads and stores address one shared data memory. Each lane forms its address as the instruction's immediate plus its own lane index, so the lanes touch neighbouring, distinct words. The lanes that pass the predicate take turns on the single memory port, lowest lane first. The instruction handshake stays closed until the last of them has been served. An if/else is run as two instructions: one predicated on a condition and one on its inverse.

Top module: `simd_pred_array`

## Requirements
- R1: After reset every register and condition-code flag of every lane is zero, `instReady` is 1, and `memReq` and `done` are 0.
- R2: An accepted non-memory instruction applies the same operation in every passing lane to that lane's own registers: opcode 1 writes rd=imm, 2 writes rd=rs1+rs2, 3 writes rd=rs1-rs2, 4 writes rd=rs1+imm, 0 does nothing. All arithmetic wraps at DW bits.
- R3: Opcode 5 (compare) sets, in each passing lane, the sign flag to (rs1 < rs2 as signed DW-bit numbers) and the zero flag to (rs1 == rs2).
- R4: The predicate field selects the lane test: 0 always, 1 zero flag set, 2 zero flag clear, 3 sign flag clear, 4 sign flag set, and 5 to 7 never.
- R5: A lane whose test fails keeps all of its registers and both flags unchanged.
- R6: A lane whose test fails makes no memory access. A load or store with no passing lane makes no request at all.
- R7: The memory word of lane L is at (imm + L) modulo 2^AW. Opcode 6 (load) writes the word read in the same cycle into rd. Opcode 7 (store) drives rs1 on `memWdata` with `memWe` = 1.
- R8: A load or store with k passing lanes makes exactly k requests, one per cycle, in the k cycles after the accept cycle, in ascending lane order. `instReady` is 0 during those cycles.
- R9: `done` is a one-cycle pulse. It comes one cycle after the accept for a non-memory instruction or for a memory instruction with no passing lane, and k+1 cycles after the accept when k lanes access memory.
- R10: An if/else run as a pass predicated on a flag test followed by a pass on the inverse test leaves each lane holding the result of exactly one of the two branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction present |
| instReady | output | 1 | Block can accept an instruction this cycle |
| instOp | input | 3 | Opcode |
| instRd | input | $clog2(NREG) | Destination register |
| instRs1 | input | $clog2(NREG) | First source register (store data source) |
| instRs2 | input | $clog2(NREG) | Second source register |
| instImm | input | DW | Immediate / memory base |
| instPred | input | 3 | Predicate test select |
| memReq | output | 1 | Memory access this cycle |
| memWe | output | 1 | 1 for a store, 0 for a load |
| memAddr | output | AW | Word address |
| memWdata | output | DW | Store data |
| memRdata | input | DW | Load data for the current address, same cycle |
| done | output | 1 | Instruction completed |

## Verification
The bench attacks the predicate paths: a wrong decode of one test code, or writeback that ignores the test, shows up as a wrong value in a later store from the affected lane. Memory instructions with only some lanes passing catch a design that still issues a request for a failed lane, or serves lanes in the wrong order. Both appear as a mismatch against the expected request queue. A memory instruction with every lane failing, and a base address near the top of memory, catch a stall that never ends, a missing done pulse, and an address that does not wrap. A compare that is itself predicated checks that flags of failed lanes survive.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_LDI  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_ADDI = 3'd4,
    OP_CMP  = 3'd5,
    OP_LD   = 3'd6,
    OP_ST   = 3'd7
  } op_e;

  localparam logic [2:0] PR_ALWAYS = 3'd0;
  localparam logic [2:0] PR_ZERO   = 3'd1;
  localparam logic [2:0] PR_NZERO  = 3'd2;
  localparam logic [2:0] PR_NNEG   = 3'd3;
  localparam logic [2:0] PR_NEG    = 3'd4;

  // strobes from sequencer to lanes
  typedef struct packed {
    logic accept;
    logic aluCommit;
    logic memGo;
  } ctrl_t;

  function automatic logic predOk(input logic [2:0] sel, input logic signF, input logic zeroF);
    case (sel)
      PR_ALWAYS: predOk = 1'b1;
      PR_ZERO:   predOk = zeroF;
      PR_NZERO:  predOk = !zeroF;
      PR_NNEG:   predOk = !signF;
      PR_NEG:    predOk = signF;
      default:   predOk = 1'b0;
    endcase
  endfunction

  function automatic logic isMemOp(input logic [2:0] op);
    isMemOp = (op == OP_LD) || (op == OP_ST);
  endfunction

endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
#(
  parameter int LANES = 4,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  logic [2:0]       instOp,
  input  logic [LANES-1:0] passMask,
  output logic             instReady,
  output ctrl_t            ctl,
  output logic [LW-1:0]    memLane,
  output logic             done
);

  logic             busy;
  logic [LANES-1:0] pending;
  logic [LANES-1:0] remaining;

  // lowest pending lane goes first
  always_comb begin
    memLane = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pending[i]) memLane = LW'(i);
    end
  end

  assign remaining     = pending & ~(LANES'(1) << memLane);
  assign instReady     = !busy;
  assign ctl.accept    = instValid && !busy;
  assign ctl.aluCommit = ctl.accept && !isMemOp(instOp);
  assign ctl.memGo     = busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      pending <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ctl.accept) begin
        if (isMemOp(instOp) && (|passMask)) begin
          busy    <= 1'b1;
          pending <= passMask;
        end else begin
          done <= 1'b1;
        end
      end
      if (busy) begin
        pending <= remaining;
        if (remaining == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/simd_lanes.sv
module simd_lanes
  import simd_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DW    = 16,
  parameter int NREG  = 8,
  parameter int AW    = 8,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int RW = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctl,
  input  logic [LW-1:0]    memLane,
  input  logic [2:0]       instOp,
  input  logic [RW-1:0]    instRd,
  input  logic [RW-1:0]    instRs1,
  input  logic [RW-1:0]    instRs2,
  input  logic [DW-1:0]    instImm,
  input  logic [2:0]       instPred,
  input  logic [DW-1:0]    memRdata,
  output logic [LANES-1:0] passMask,
  output logic             memWe,
  output logic [AW-1:0]    memAddr,
  output logic [DW-1:0]    memWdata
);

  // memory instruction held while lanes take turns on the port
  logic [2:0]    heldOp;
  logic [RW-1:0] heldRd;
  logic [RW-1:0] heldRs1;
  logic [AW-1:0] heldBase;
  logic [DW-1:0] laneStore [LANES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldOp   <= OP_NOP;
      heldRd   <= '0;
      heldRs1  <= '0;
      heldBase <= '0;
    end else if (ctl.accept) begin
      heldOp   <= instOp;
      heldRd   <= instRd;
      heldRs1  <= instRs1;
      heldBase <= instImm[AW-1:0];
    end
  end

  assign memWe    = (heldOp == OP_ST);
  assign memAddr  = heldBase + AW'(memLane);
  assign memWdata = laneStore[memLane];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [DW-1:0] regs [NREG];
    logic          signF;
    logic          zeroF;
    logic [DW-1:0] opA;
    logic [DW-1:0] opB;
    logic [DW-1:0] result;
    logic          writesReg;

    assign opA          = regs[instRs1];
    assign opB          = regs[instRs2];
    assign passMask[g]  = predOk(instPred, signF, zeroF);
    assign laneStore[g] = regs[heldRs1];

    always_comb begin
      result    = '0;
      writesReg = 1'b1;
      case (instOp)
        OP_LDI:  result = instImm;
        OP_ADD:  result = opA + opB;
        OP_SUB:  result = opA - opB;
        OP_ADDI: result = opA + instImm;
        default: writesReg = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int r = 0; r < NREG; r++) regs[r] <= '0;
        signF <= 1'b0;
        zeroF <= 1'b0;
      end else begin
        if (ctl.aluCommit && passMask[g]) begin
          if (instOp == OP_CMP) begin
            signF <= $signed(opA) < $signed(opB);
            zeroF <= (opA == opB);
          end else if (writesReg) begin
            regs[instRd] <= result;
          end
        end
        if (ctl.memGo && heldOp == OP_LD && memLane == LW'(g)) begin
          regs[heldRd] <= memRdata;
        end
      end
    end
  end

endmodule

// File: rtl/simd_pred_array.sv
module simd_pred_array
  import simd_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DW    = 16,
  parameter int NREG  = 8,
  parameter int AW    = 8,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          instValid,
  output logic          instReady,
  input  logic [2:0]    instOp,
  input  logic [RW-1:0] instRd,
  input  logic [RW-1:0] instRs1,
  input  logic [RW-1:0] instRs2,
  input  logic [DW-1:0] instImm,
  input  logic [2:0]    instPred,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  output logic          done
);

  ctrl_t            ctl;
  logic [LW-1:0]    memLane;
  logic [LANES-1:0] passMask;

  simd_ctrl #(.LANES(LANES)) uCtrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOp(instOp),
    .passMask(passMask), .instReady(instReady), .ctl(ctl),
    .memLane(memLane), .done(done)
  );

  simd_lanes #(.LANES(LANES), .DW(DW), .NREG(NREG), .AW(AW)) uLanes (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memLane(memLane),
    .instOp(instOp), .instRd(instRd), .instRs1(instRs1), .instRs2(instRs2),
    .instImm(instImm), .instPred(instPred), .memRdata(memRdata),
    .passMask(passMask), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

  assign memReq = ctl.memGo;

endmodule

// File: rtl/simd_pred_array_chk.sv
module simd_pred_array_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          instReady,
  input logic          memReq,
  input logic          memWe,
  input logic [AW-1:0] memAddr,
  input logic          done
);

  // R8: handshake closed while lanes use the port
  a_r8_stall_during_access: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !instReady);

  // R8: one instruction's accesses are all of one kind
  a_r8_kind_steady: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && $past(memReq)) |-> (memWe == $past(memWe)));

  // R7: successive lanes touch distinct words
  a_r7_distinct_words: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && $past(memReq)) |-> (memAddr != $past(memAddr)));

  // R9: completion right after the last access
  a_r9_done_after_access: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memReq) |-> done);

  // R9: completion leaves the block ready
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> instReady);

endmodule

bind simd_pred_array simd_pred_array_chk #(.AW(AW)) uChk (
  .clk(clk), .rstN(rstN), .instReady(instReady), .memReq(memReq),
  .memWe(memWe), .memAddr(memAddr), .done(done)
);

// File: tb/tb_simd_pred_array.sv
module tb_simd_pred_array;

  localparam int LANES = 4;
  localparam int DW = 16;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0;
  logic instReady;
  logic [2:0] instOp = '0;
  logic [2:0] instRd = '0, instRs1 = '0, instRs2 = '0;
  logic [DW-1:0] instImm = '0;
  logic [2:0] instPred = '0;
  logic memReq, memWe, done;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata, memRdata;

  always #4 clk = ~clk;

  simd_pred_array dut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instReady(instReady),
    .instOp(instOp), .instRd(instRd), .instRs1(instRs1), .instRs2(instRs2),
    .instImm(instImm), .instPred(instPred), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .done(done)
  );

  // external memory
  logic [DW-1:0] mem [256];
  assign memRdata = mem[memAddr];
  always @(posedge clk) if (memReq && memWe) mem[memAddr] <= memWdata;

  // reference state
  logic [DW-1:0] mReg [LANES][8];
  bit mSign [LANES];
  bit mZero [LANES];
  int nChecks = 0;
  int nFails = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit testOk(input int sel, input bit s, input bit z);
    case (sel)
      0: return 1'b1;
      1: return z;
      2: return !z;
      3: return !s;
      4: return s;
      default: return 1'b0;
    endcase
  endfunction

  task automatic issue(input int op, input int rd, input int rs1, input int rs2,
                       input int imm, input int pr, input string req);
    bit expWe [$];
    int expAddr [$];
    int expData [$];
    int lat;
    int expLat;
    int k = 0;
    for (int l = 0; l < LANES; l++) begin
      logic [DW-1:0] a, b;
      a = mReg[l][rs1];
      b = mReg[l][rs2];
      if (!testOk(pr, mSign[l], mZero[l])) continue;
      case (op)
        1: mReg[l][rd] = DW'(imm);
        2: mReg[l][rd] = a + b;
        3: mReg[l][rd] = a - b;
        4: mReg[l][rd] = a + DW'(imm);
        5: begin mSign[l] = $signed(a) < $signed(b); mZero[l] = (a == b); end
        6: begin
          expWe.push_back(1'b0); expAddr.push_back((imm + l) % 256); expData.push_back(0);
          mReg[l][rd] = mem[(imm + l) % 256];
          k++;
        end
        7: begin
          expWe.push_back(1'b1); expAddr.push_back((imm + l) % 256); expData.push_back(int'(a));
          k++;
        end
        default: ;
      endcase
    end
    expLat = (k > 0) ? k + 1 : 1;
    @(negedge clk);
    instOp = 3'(op); instRd = 3'(rd); instRs1 = 3'(rs1); instRs2 = 3'(rs2);
    instImm = DW'(imm); instPred = 3'(pr); instValid = 1'b1;
    @(negedge clk);
    instValid = 1'b0;
    lat = 1;
    forever begin
      if (memReq) begin
        if (expAddr.size() == 0) begin
          chk(1'b0, req, "unexpected memory request addr", int'(memAddr), -1);
        end else begin
          bit w;
          int ad;
          int dt;
          w = expWe.pop_front(); ad = expAddr.pop_front(); dt = expData.pop_front();
          chk(memAddr == AW'(ad), req, "request address", int'(memAddr), ad);   // R7 R8
          chk(memWe == w, req, "request kind", int'(memWe), int'(w));
          if (w) chk(memWdata == DW'(dt), req, "store data", int'(memWdata), dt);
        end
        chk(!instReady, "R8", "ready during access", int'(instReady), 0);
      end
      if (done || lat > 40) break;
      @(negedge clk);
      lat++;
    end
    chk(lat == expLat, "R9", {req, " latency to done"}, lat, expLat);
    chk(expAddr.size() == 0, req, "requests missing", expAddr.size(), 0);
  endtask

  initial begin
    #(200000 * 8);
    chk(1'b0, "watchdog", "run did not finish", 0, 1);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = DW'(i * 3 + 1);
    mem[8'h20] = 16'd5; mem[8'h21] = 16'hFFFD; mem[8'h22] = 16'd7; mem[8'h23] = 16'd0;
    for (int l = 0; l < LANES; l++) begin
      for (int r = 0; r < 8; r++) mReg[l][r] = '0;
      mSign[l] = 0; mZero[l] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(instReady == 1'b1, "R1", "ready after reset", int'(instReady), 1);
    chk(memReq == 1'b0, "R1", "memReq after reset", int'(memReq), 0);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    issue(7, 0, 5, 0, 'h40, 0, "R1");          // store zeros, order lanes 0..3
    issue(6, 1, 0, 0, 'h20, 0, "R7");          // load lane data
    issue(4, 3, 1, 0, 100, 0, "R2");           // r3 = r1 + 100
    issue(7, 0, 3, 0, 'h30, 0, "R2");
    issue(3, 2, 3, 1, 0, 0, "R2");             // r2 = r3 - r1
    issue(7, 0, 2, 0, 'h50, 0, "R2");
    issue(5, 0, 1, 0, 0, 0, "R3");             // cmp r1, r0
    issue(1, 4, 0, 0, 1, 3, "R4");             // r4 = 1 where not negative
    issue(7, 0, 4, 0, 'h60, 0, "R5");
    issue(4, 6, 1, 0, 100, 3, "R10");          // then branch
    issue(4, 6, 1, 0, 10, 4, "R10");           // else branch
    issue(7, 0, 6, 0, 'h70, 0, "R10");
    issue(7, 0, 1, 0, 'h80, 2, "R6");          // lanes with nonzero flag clear
    issue(7, 0, 1, 0, 'h90, 1, "R6");          // only the zero lane
    issue(2, 1, 1, 1, 0, 6, "R9");             // never: still one cycle
    issue(7, 0, 1, 0, 'hA0, 0, "R5");
    issue(6, 1, 0, 0, 'h20, 7, "R6");          // load, no lane passes
    issue(7, 0, 1, 0, 'hFE, 0, "R7");          // address wraps
    issue(5, 0, 0, 1, 0, 4, "R3");             // compare only in negative lane
    issue(1, 7, 0, 0, 9, 4, "R5");
    issue(7, 0, 7, 0, 'hB0, 0, "R5");
    issue(1, 7, 0, 0, 3, 1, "R4");             // zero-flag lane only
    issue(7, 0, 7, 0, 'hC0, 0, "R4");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule